// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block watches the data bus of a NAND flash interface and builds a 24-bit Hamming code over one sector while the bytes go past. It works on 8-bit or 16-bit wide columns. For every bit-address line and every byte-address line it keeps two running parities: one over the bits whose address has that line at 0 (the even half) and one over the bits whose address has that line at 1 (the odd half). Comparing the stored code with a freshly computed one lets software find and flip a single failing bit.

Software pulses `clear`, sets the sector length and the column width, and then enables the engine. Each accepted transfer is folded into the accumulators. Once the last byte of the sector has been taken, the code is latched into a 32-bit result word and `done` goes high. From then on the bus is ignored until the next clear. The same code is also offered as three packed bytes, ready to be written to the spare area. The code is not inverted, so a sector of all 0xFF bytes gives an all-zero code.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset `result`, `ecc_bytes` and `done` are all zero.
- R2: The bit address of data bit b of sector byte n is n*8+b. For weight index w from 0 to 11 (address bit w; weights 1, 2 and 4 come from b, weights 8 to 2048 from n), `result[w]` is the XOR of all data bits whose address bit w is 0, and `result[16+w]` is the XOR of all data bits whose address bit w is 1. Bits 12 to 15 and 28 to 31 read zero.
- R3: When `cfg_wide` is 1, each transfer carries two sector bytes: `bus_data[7:0]` is byte n and `bus_data[15:8]` is byte n+1. When `cfg_wide` is 0, only `bus_data[7:0]` is used and each transfer carries one byte.
- R4: The sector holds 2*(`size_half_m1`+1) bytes. `done` stays low until the transfer that brings in the last byte. On the clock edge that accepts that transfer, `done` is set and `result` takes the final code.
- R5: While `done` is high, bus transfers change neither `result` nor `done`.
- R6: A `clear` sampled on a clock edge zeros the accumulators, the byte count, `result` and `done`. A transfer on the same edge is discarded.
- R7: While `cfg_en` is 0, transfers are ignored and do not advance the byte count.
- R8: `ecc_bytes[7:0]` = `result[7:0]`, `ecc_bytes[15:8]` = `result[23:16]`, `ecc_bytes[19:16]` = `result[11:8]`, `ecc_bytes[23:20]` = `result[27:24]`.
- R9: The code is not inverted: a sector of all-0xFF bytes yields a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Engine enable |
| cfg_wide | input | 1 | 1 = 16-bit columns, 0 = 8-bit columns |
| clear | input | 1 | Clears accumulators, count, result and done |
| size_half_m1 | input | SEC_AW-1 | Sector length in bytes, halved, minus one |
| bus_valid | input | 1 | A data transfer is on the bus this cycle |
| bus_data | input | 16 | Bus data, low byte first |
| result | output | 32 | Frozen code: even halves in bits 0-11, odd halves in bits 16-27 |
| ecc_bytes | output | 24 | Code packed as three bytes |
| done | output | 1 | Sector complete, result valid |

## Verification
A clear and a bus transfer can both be sampled on one clock edge. The bench provokes this partway through a sector: `clear` and `bus_valid` are raised together with non-zero data. It then checks that `result` and `done` read zero and that the next full sector gives exactly the code of the new data alone. If the stray byte had been counted, the byte indices would shift and the code would be wrong. The second overlap is a transfer that arrives while `done` is already high; the bench checks that `result` holds its value.

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int SEC_AW = 9,
  parameter int SIZE_W = SEC_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_wide,
  input  logic              clear,
  input  logic [SIZE_W-1:0] size_half_m1,
  input  logic              bus_valid,
  input  logic [15:0]       bus_data,
  output logic [31:0]       result,
  output logic [23:0]       ecc_bytes,
  output logic              done
);
  localparam int NW = SEC_AW + 3;
  localparam int CW = SEC_AW + 1;

  function automatic logic [2*NW-1:0] byte_par(input logic [7:0] d, input logic [SEC_AW-1:0] idx);
    logic [NW-1:0] ev, od;
    ev = '0;
    od = '0;
    for (int i = 0; i < 3; i++)
      for (int b = 0; b < 8; b++)
        if (b[i]) od[i] ^= d[b];
        else      ev[i] ^= d[b];
    for (int j = 0; j < SEC_AW; j++)
      if (idx[j]) od[3+j] = ^d;
      else        ev[3+j] = ^d;
    return {od, ev};
  endfunction

  logic [2*NW-1:0] acc_q, res_q, contrib;
  logic [CW-1:0]   cnt_q, cnt_nxt, total;
  logic            done_q, take, last;

  assign take    = cfg_en && bus_valid && !done_q;
  assign total   = CW'({size_half_m1, 1'b0}) + CW'(2);
  assign cnt_nxt = cnt_q + (cfg_wide ? CW'(2) : CW'(1));
  assign last    = cnt_nxt >= total;
  assign contrib = byte_par(bus_data[7:0], cnt_q[SEC_AW-1:0]) ^
                   (cfg_wide ? byte_par(bus_data[15:8], SEC_AW'(cnt_q + CW'(1))) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clear) begin
      acc_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      acc_q <= acc_q ^ contrib;
      cnt_q <= cnt_nxt;
      if (last) begin
        done_q <= 1'b1;
        res_q  <= acc_q ^ contrib;
      end
    end
  end

  always_comb begin
    result           = '0;
    result[NW-1:0]   = res_q[NW-1:0];
    result[16 +: NW] = res_q[NW +: NW];
  end

  assign ecc_bytes = {result[27:24], result[11:8], result[23:16], result[7:0]};
  assign done      = done_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> ($stable(result) && done));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!done && result == 32'h0));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !clear) |=> ($stable(acc_q) && $stable(cnt_q)));

  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_valid && cfg_en && !clear));
endmodule

// File: tb/test_nand_hamming_ecc.sv
module test_nand_hamming_ecc;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_wide = 1'b0, clear = 1'b0, bus_valid = 1'b0;
  logic [7:0]  size_half_m1 = '0;
  logic [15:0] bus_data = '0;
  logic [31:0] result;
  logic [23:0] ecc_bytes;
  logic        done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  nand_hamming_ecc i_nand_hamming_ecc (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wide(cfg_wide), .clear(clear),
    .size_half_m1(size_half_m1), .bus_valid(bus_valid), .bus_data(bus_data),
    .result(result), .ecc_bytes(ecc_bytes), .done(done));

  // fields: [16:9] size_half_m1, [8] wide, [7:0] seed
  localparam logic [16:0] VEC [6] = '{
    {8'd0,   1'b0, 8'h13}, {8'd3,   1'b1, 8'h5A}, {8'd7,  1'b0, 8'hC1},
    {8'd31,  1'b1, 8'h02}, {8'd255, 1'b0, 8'h77}, {8'd255, 1'b1, 8'h9E}};

  function automatic logic [7:0] dat(int kind, logic [7:0] seed, int i, int n);
    case (kind)
      0:       return 8'(i * 37 + seed * 11) ^ 8'(seed << 3) ^ 8'(i >> 2);
      1:       return 8'hFF;
      default: return (i == n - 1) ? 8'h80 : 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] model(int kind, logic [7:0] seed, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (dat(kind, seed, i, n)[b])
          for (int w = 0; w < 12; w++)
            if (((i * 8 + b) >> w) & 1) r[16+w] ^= 1'b1;
            else                        r[w]    ^= 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] size, input logic wide, input logic en);
    @(negedge clk);
    clear = 1'b1; size_half_m1 = size; cfg_wide = wide; cfg_en = en;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic feed(input int kind, input logic [7:0] seed, input int n, input logic wide, input bit chk_pre);
    int step = wide ? 2 : 1;
    for (int i = 0; i < n; i += step) begin
      if (chk_pre && i == n - step) chk(done == 1'b0, "R4 done before last", 32'(done), 0);
      bus_valid = 1'b1;
      bus_data  = wide ? {dat(kind, seed, i + 1, n), dat(kind, seed, i, n)} : {8'h5C, dat(kind, seed, i, n)};
      @(negedge clk);
    end
    bus_valid = 1'b0;
  endtask

  task automatic run(input logic [7:0] size, input logic wide, input logic [7:0] seed, input int kind);
    int n = 2 * (int'(size) + 1);
    logic [31:0] e = model(kind, seed, n);
    logic [31:0] held;
    start(size, wide, 1'b1);
    feed(kind, seed, n, wide, 1'b1);
    chk(done == 1'b1, "R4 done after last", 32'(done), 1);
    chk(result == e, wide ? "R3 wide code" : "R2 narrow code", result, e);
    chk(ecc_bytes == {e[27:24], e[11:8], e[23:16], e[7:0]}, "R8 packing", 32'(ecc_bytes),
        32'({e[27:24], e[11:8], e[23:16], e[7:0]}));
    held = result;
    for (int k = 0; k < 3; k++) begin
      bus_valid = 1'b1; bus_data = 16'hA5C3 + 16'(k);
      @(negedge clk);
    end
    bus_valid = 1'b0;
    chk(result == held && done, "R5 frozen", result, held);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12;
    chk(result == 0 && ecc_bytes == 0 && done == 0, "R1 reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 0 && done == 0, "R1 after reset", result, 0);

    foreach (VEC[v]) run(VEC[v][16:9], VEC[v][8], VEC[v][7:0], 0);

    run(8'd255, 1'b1, 8'h00, 1);
    chk(result == 32'h0, "R9 erased sector", result, 0);
    run(8'd255, 1'b0, 8'h00, 2);
    chk(result == 32'h0FFF0000, "R2 last bit odd", result, 32'h0FFF0000);

    // R7: disabled engine ignores the bus
    start(8'd0, 1'b0, 1'b0);
    feed(0, 8'h44, 4, 1'b0, 1'b0);
    chk(done == 0 && result == 0, "R7 disabled", result, 0);
    cfg_en = 1'b1;
    feed(0, 8'h21, 2, 1'b0, 1'b0);
    chk(result == model(0, 8'h21, 2), "R7 count not advanced", result, model(0, 8'h21, 2));

    // R6: clear meets a transfer on the same edge
    start(8'd3, 1'b0, 1'b1);
    feed(0, 8'h99, 3, 1'b0, 1'b0);
    @(negedge clk);
    clear = 1'b1; bus_valid = 1'b1; bus_data = 16'h00FF;
    @(negedge clk);
    clear = 1'b0; bus_valid = 1'b0;
    chk(done == 0 && result == 0, "R6 cleared", result, 0);
    feed(0, 8'h3B, 8, 1'b0, 1'b0);
    chk(result == model(0, 8'h3B, 8), "R6 transfer discarded", result, model(0, 8'h3B, 8));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule